// File: doc/BRIEF.md
# SDRAM Refresh Scheduler

This block tells an SDRAM access sequencer when an auto-refresh is due and runs the refresh command sequence once the sequencer hands over the bus. A 12-bit interval value sets how many controller clocks pass between refresh slots. Each time that interval expires, the block raises a request. The request stays up until the sequencer grants it at an access boundary.

The block also tracks the single page the sequencer may keep open, by bank and row. It flags an access that would need that page closed first. When a refresh is granted, any open row is closed with a precharge-all. The auto-refresh command follows after the row-precharge time. A busy output then covers the recovery time, taken as row-active time plus row-precharge time. The interval value is the refresh period per row in clocks minus that recovery time. A package function computes it from clock rate, refresh period, row count and the two timings.

Expiries that arrive while a refresh is still owed are counted, so that none is lost. A sticky flag reports when the count would exceed its depth. An interval of zero while enabled is reported as a configuration error, and no refresh is scheduled from it.

Top module: `sdram_refresh_sched`

## Requirements
- R1: With enable first sampled high at a clock edge and interval N (1..4095), `ref_req_o` rises N clock edges later. Later expiries follow every N cycles.
- R2: The package function `calc_interval(clk_khz, period_ms, rows, t_ras, t_rp)` returns floor(clk_khz*period_ms/rows) - (t_ras + t_rp). For example, (133000, 64, 8192, 6, 3) gives 1030.
- R3: While enabled with interval 0, `cfg_err_o` is 1 and `ref_req_o` never rises.
- R4: A raised request stays high until `ref_gnt_i` is sampled high with it. A grant while no request is up causes no command and no busy.
- R5: If a row is open at the grant edge, `cmd_pre_all_o` pulses for one cycle in the cycle after that edge. `cmd_refresh_o` pulses exactly `t_rp_i` cycles after it (with `t_rp_i` >= 1). The two commands are never high together.
- R6: If no row is open at the grant edge, `cmd_refresh_o` pulses in the cycle after that edge and no precharge-all is issued.
- R7: `busy_o` is high from the cycle after the grant until `t_ras_i + t_rp_i` cycles after the auto-refresh cycle. After that, `row_open_o` is 0. `ref_req_o` is never high while busy.
- R8: An expiry while one refresh is owed makes two owed. The request returns in the first idle cycle after the first refresh. An expiry while two are owed sets `owed_ovf_o`, which stays set until enable drops.
- R9: Deasserting enable clears the countdown, the owed count, the overflow flag and the open-row state. After reset, all outputs are 0.
- R10: `acc_act_i` records `acc_bank_i`/`acc_row_i` as the open page, and `acc_pre_i` closes it. `acc_conflict_o` is 1 when a page is open and the presented bank or row differs from it. Activations while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Scheduler enable |
| interval_i | input | INTV_W (12) | Refresh interval in clocks |
| t_ras_i | input | TCYC_W (4) | Row-active time in clocks |
| t_rp_i | input | TCYC_W (4) | Row-precharge time in clocks |
| acc_act_i | input | 1 | Sequencer activated the presented bank/row |
| acc_pre_i | input | 1 | Sequencer closed the open row |
| acc_bank_i | input | BANK_W (2) | Bank of the current access |
| acc_row_i | input | ROW_W (13) | Row of the current access |
| ref_gnt_i | input | 1 | Sequencer grants the refresh slot |
| ref_req_o | output | 1 | Refresh owed and block idle |
| cmd_pre_all_o | output | 1 | Precharge-all command strobe |
| cmd_refresh_o | output | 1 | Auto-refresh command strobe |
| busy_o | output | 1 | Refresh sequence in progress |
| row_open_o | output | 1 | A page is open |
| open_bank_o | output | BANK_W (2) | Bank of the open page |
| open_row_o | output | ROW_W (13) | Row of the open page |
| acc_conflict_o | output | 1 | Current access needs the open page closed first |
| cfg_err_o | output | 1 | Enabled with interval 0 |
| owed_ovf_o | output | 1 | Owed-refresh count overflowed |

## Verification
The refresh sequence is run from a table of intervals, timings and open-row states. The intervals include 1, small values and larger values, and the timings include the 1-cycle minimum. This separates off-by-one errors in the countdown reload from errors in the precharge wait or the recovery window. Rows open against rows closed shows whether the precharge-all branch is taken only when needed. Directed sequences cover the other cases. Two expiries with no grant, then three, set apart the owed count from the overflow flag. A zero interval and a grant with no request check that nothing is issued. Pages in the same bank with another row, and in another bank with the same row, check the conflict compare on each field.

// File: rtl/refresh_pkg.sv
package refresh_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_PRE_WAIT,
    ST_REF,
    ST_REF_WAIT
  } ref_state_e;

  // clocks per row minus refresh recovery (t_ras + t_rp)
  function automatic int unsigned calc_interval(input int unsigned clk_khz,
                                                input int unsigned period_ms,
                                                input int unsigned rows,
                                                input int unsigned t_ras,
                                                input int unsigned t_rp);
    int unsigned per_row;
    per_row = (clk_khz * period_ms) / rows;
    return per_row - (t_ras + t_rp);
  endfunction

endpackage

// File: rtl/refresh_timer.sv
module refresh_timer #(
  parameter int INTV_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [INTV_W-1:0] interval_i,
  output logic              tick_o
);
  logic [INTV_W-1:0] cnt_q;
  logic              armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (!armed_q) begin
      cnt_q   <= interval_i;
      armed_q <= 1'b1;
    end else if (cnt_q == INTV_W'(1)) begin
      cnt_q <= interval_i;
    end else begin
      cnt_q <= cnt_q - INTV_W'(1);
    end
  end

  assign tick_o = run_i && armed_q && (cnt_q == INTV_W'(1));
endmodule

// File: rtl/refresh_debt.sv
module refresh_debt #(
  parameter int MAX_OWED = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic tick_i,
  input  logic take_i,
  output logic owed_nz_o,
  output logic ovf_o
);
  localparam int OW = $clog2(MAX_OWED + 1);

  logic [OW-1:0] owed_q;
  logic          ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owed_q <= '0;
      ovf_q  <= 1'b0;
    end else if (!enable_i) begin
      owed_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      unique case ({tick_i, take_i})
        2'b10: begin
          if (owed_q == OW'(MAX_OWED)) ovf_q <= 1'b1;
          else                         owed_q <= owed_q + OW'(1);
        end
        2'b01:   owed_q <= owed_q - OW'(1);
        default: owed_q <= owed_q;
      endcase
    end
  end

  assign owed_nz_o = (owed_q != '0);
  assign ovf_o     = ovf_q;
endmodule

// File: rtl/refresh_fsm.sv
module refresh_fsm
  import refresh_pkg::*;
#(
  parameter int TCYC_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              owed_nz_i,
  input  logic              gnt_i,
  input  logic              row_open_i,
  input  logic [TCYC_W-1:0] t_ras_i,
  input  logic [TCYC_W-1:0] t_rp_i,
  output logic              req_o,
  output logic              take_o,
  output logic              pre_o,
  output logic              ref_o,
  output logic              busy_o
);
  localparam int TW = TCYC_W + 1;

  ref_state_e    state_q;
  logic [TW-1:0] wcnt_q;
  logic [TW-1:0] trc;
  logic [TW-1:0] trp_ext;

  assign trp_ext = {1'b0, t_rp_i};
  assign trc     = {1'b0, t_ras_i} + trp_ext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      wcnt_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (take_o) state_q <= row_open_i ? ST_PRE : ST_REF;
        end
        ST_PRE: begin
          if (trp_ext <= TW'(1)) begin
            state_q <= ST_REF;
          end else begin
            state_q <= ST_PRE_WAIT;
            wcnt_q  <= trp_ext - TW'(1);
          end
        end
        ST_PRE_WAIT: begin
          if (wcnt_q <= TW'(1)) state_q <= ST_REF;
          else                  wcnt_q  <= wcnt_q - TW'(1);
        end
        ST_REF: begin
          if (trc <= TW'(1)) begin
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_REF_WAIT;
            wcnt_q  <= trc - TW'(1);
          end
        end
        ST_REF_WAIT: begin
          if (wcnt_q <= TW'(1)) state_q <= ST_IDLE;
          else                  wcnt_q  <= wcnt_q - TW'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_o  = (state_q == ST_IDLE) && owed_nz_i;
  assign take_o = req_o && gnt_i;
  assign pre_o  = (state_q == ST_PRE);
  assign ref_o  = (state_q == ST_REF);
  assign busy_o = (state_q != ST_IDLE);
endmodule

// File: rtl/open_row_track.sv
module open_row_track #(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              busy_i,
  input  logic              close_i,
  input  logic              act_i,
  input  logic              pre_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [ROW_W-1:0]  row_i,
  output logic              open_o,
  output logic [BANK_W-1:0] open_bank_o,
  output logic [ROW_W-1:0]  open_row_o,
  output logic              conflict_o
);
  logic              open_q;
  logic [BANK_W-1:0] bank_q;
  logic [ROW_W-1:0]  row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      bank_q <= '0;
      row_q  <= '0;
    end else if (!enable_i || close_i) begin
      open_q <= 1'b0;
      bank_q <= '0;
      row_q  <= '0;
    end else if (!busy_i) begin
      if (act_i) begin
        open_q <= 1'b1;
        bank_q <= bank_i;
        row_q  <= row_i;
      end else if (pre_i) begin
        open_q <= 1'b0;
      end
    end
  end

  assign open_o      = open_q;
  assign open_bank_o = bank_q;
  assign open_row_o  = row_q;
  assign conflict_o  = open_q && ((bank_i != bank_q) || (row_i != row_q));
endmodule

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched #(
  parameter int INTV_W   = 12,
  parameter int TCYC_W   = 4,
  parameter int BANK_W   = 2,
  parameter int ROW_W    = 13,
  parameter int MAX_OWED = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic [INTV_W-1:0] interval_i,
  input  logic [TCYC_W-1:0] t_ras_i,
  input  logic [TCYC_W-1:0] t_rp_i,
  input  logic              acc_act_i,
  input  logic              acc_pre_i,
  input  logic [BANK_W-1:0] acc_bank_i,
  input  logic [ROW_W-1:0]  acc_row_i,
  input  logic              ref_gnt_i,
  output logic              ref_req_o,
  output logic              cmd_pre_all_o,
  output logic              cmd_refresh_o,
  output logic              busy_o,
  output logic              row_open_o,
  output logic [BANK_W-1:0] open_bank_o,
  output logic [ROW_W-1:0]  open_row_o,
  output logic              acc_conflict_o,
  output logic              cfg_err_o,
  output logic              owed_ovf_o
);
  logic run, tick, owed_nz, take;

  assign cfg_err_o = enable_i && (interval_i == '0);
  assign run       = enable_i && !cfg_err_o;

  refresh_timer #(.INTV_W(INTV_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run),
    .interval_i (interval_i),
    .tick_o     (tick)
  );

  refresh_debt #(.MAX_OWED(MAX_OWED)) u_debt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .enable_i  (enable_i),
    .tick_i    (tick),
    .take_i    (take),
    .owed_nz_o (owed_nz),
    .ovf_o     (owed_ovf_o)
  );

  refresh_fsm #(.TCYC_W(TCYC_W)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .owed_nz_i  (owed_nz),
    .gnt_i      (ref_gnt_i),
    .row_open_i (row_open_o),
    .t_ras_i    (t_ras_i),
    .t_rp_i     (t_rp_i),
    .req_o      (ref_req_o),
    .take_o     (take),
    .pre_o      (cmd_pre_all_o),
    .ref_o      (cmd_refresh_o),
    .busy_o     (busy_o)
  );

  open_row_track #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_rows (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .enable_i    (enable_i),
    .busy_i      (busy_o),
    .close_i     (cmd_pre_all_o),
    .act_i       (acc_act_i),
    .pre_i       (acc_pre_i),
    .bank_i      (acc_bank_i),
    .row_i       (acc_row_i),
    .open_o      (row_open_o),
    .open_bank_o (open_bank_o),
    .open_row_o  (open_row_o),
    .conflict_o  (acc_conflict_o)
  );
endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic enable_i,
  input logic ref_req_o,
  input logic cmd_pre_all_o,
  input logic cmd_refresh_o,
  input logic busy_o,
  input logic row_open_o,
  input logic acc_conflict_o,
  input logic owed_ovf_o
);
  assert_cmd_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_pre_all_o && cmd_refresh_o));

  assert_pre_closes_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_pre_all_o |=> !row_open_o);

  assert_req_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_req_o |-> !busy_o);

  assert_ref_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_refresh_o |-> busy_o);

  assert_disable_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (!ref_req_o && !owed_ovf_o && !row_open_o));

  assert_ovf_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owed_ovf_o && enable_i) |=> owed_ovf_o);

  assert_conflict_open_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !row_open_o |-> !acc_conflict_o);
endmodule

bind sdram_refresh_sched refresh_sched_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .enable_i       (enable_i),
  .ref_req_o      (ref_req_o),
  .cmd_pre_all_o  (cmd_pre_all_o),
  .cmd_refresh_o  (cmd_refresh_o),
  .busy_o         (busy_o),
  .row_open_o     (row_open_o),
  .acc_conflict_o (acc_conflict_o),
  .owed_ovf_o     (owed_ovf_o)
);

// File: tb/tb_sdram_refresh_sched.sv
module tb_sdram_refresh_sched;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // interval, t_ras, t_rp, row open, expected refresh cycle, expected idle cycle
  localparam int V_INT [NVEC] = '{7, 1, 30, 12, 3, 50};
  localparam int V_RAS [NVEC] = '{6, 2, 6, 4, 1, 7};
  localparam int V_RP  [NVEC] = '{3, 1, 3, 2, 1, 5};
  localparam int V_ROW [NVEC] = '{1, 0, 0, 1, 1, 1};
  localparam int V_EREF[NVEC] = '{4, 1, 1, 3, 2, 6};
  localparam int V_EIDL[NVEC] = '{13, 4, 10, 9, 4, 18};

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        enable_i = 1'b0;
  logic [11:0] interval_i = '0;
  logic [3:0]  t_ras_i = 4'd6;
  logic [3:0]  t_rp_i = 4'd3;
  logic        acc_act_i = 1'b0;
  logic        acc_pre_i = 1'b0;
  logic [1:0]  acc_bank_i = '0;
  logic [12:0] acc_row_i = '0;
  logic        ref_gnt_i = 1'b0;
  logic        ref_req_o, cmd_pre_all_o, cmd_refresh_o, busy_o, row_open_o;
  logic [1:0]  open_bank_o;
  logic [12:0] open_row_o;
  logic        acc_conflict_o, cfg_err_o, owed_ovf_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sdram_refresh_sched dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .enable_i(enable_i), .interval_i(interval_i),
    .t_ras_i(t_ras_i), .t_rp_i(t_rp_i), .acc_act_i(acc_act_i), .acc_pre_i(acc_pre_i),
    .acc_bank_i(acc_bank_i), .acc_row_i(acc_row_i), .ref_gnt_i(ref_gnt_i),
    .ref_req_o(ref_req_o), .cmd_pre_all_o(cmd_pre_all_o), .cmd_refresh_o(cmd_refresh_o),
    .busy_o(busy_o), .row_open_o(row_open_o), .open_bank_o(open_bank_o),
    .open_row_o(open_row_o), .acc_conflict_o(acc_conflict_o), .cfg_err_o(cfg_err_o),
    .owed_ovf_o(owed_ovf_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle_off();
    enable_i = 1'b0; ref_gnt_i = 1'b0; acc_act_i = 1'b0; acc_pre_i = 1'b0;
    repeat (2) @(negedge clk_i);
  endtask

  // grant at this negedge; returns cycle numbers counted from the grant edge
  task automatic grant_run(output int t_pre, output int t_ref, output int t_idle,
                           output int npre, output int busy1);
    t_pre = 0; t_ref = 0; t_idle = 0; npre = 0; busy1 = 0;
    ref_gnt_i = 1'b1;
    for (int t = 1; t <= 80; t++) begin
      @(negedge clk_i);
      ref_gnt_i = 1'b0;
      if (t == 1) busy1 = busy_o;
      if (cmd_pre_all_o) begin npre++; if (t_pre == 0) t_pre = t; end
      if (cmd_refresh_o && t_ref == 0) t_ref = t;
      if (!busy_o) begin t_idle = t; break; end
    end
  endtask

  task automatic wait_req(output int k);
    k = 0;
    for (int i = 1; i <= 5000; i++) begin
      @(negedge clk_i);
      if (ref_req_o) begin k = i; break; end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int k, tp, tr, ti, np, b1;
    repeat (3) @(negedge clk_i);
    // R9 reset state
    chk("R9 reset req", int'(ref_req_o), 0);
    chk("R9 reset busy", int'(busy_o), 0);
    chk("R9 reset row_open", int'(row_open_o), 0);
    chk("R9 reset cmds", int'(cmd_pre_all_o | cmd_refresh_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2 interval helper
    chk("R2 calc_interval", int'(refresh_pkg::calc_interval(133000, 64, 8192, 6, 3)), 1030);

    // table of sequences: R1 R5 R6 R7 R10
    for (int v = 0; v < NVEC; v++) begin
      idle_off();
      interval_i = 12'(V_INT[v]); t_ras_i = 4'(V_RAS[v]); t_rp_i = 4'(V_RP[v]);
      acc_bank_i = 2'd1; acc_row_i = 13'(100 + v);
      enable_i = 1'b1;
      acc_act_i = (V_ROW[v] != 0);
      wait_req(k);
      acc_act_i = 1'b0;
      chk($sformatf("R1 vec%0d first request edge", v), k, V_INT[v] + 1);
      chk($sformatf("R10 vec%0d row_open", v), int'(row_open_o), V_ROW[v]);
      grant_run(tp, tr, ti, np, b1);
      chk($sformatf("R7 vec%0d busy after grant", v), b1, 1);
      chk($sformatf("R5 vec%0d precharge count", v), np, V_ROW[v]);
      if (V_ROW[v] != 0) chk($sformatf("R5 vec%0d precharge cycle", v), tp, 1);
      chk($sformatf("R5 R6 vec%0d refresh cycle", v), tr, V_EREF[v]);
      chk($sformatf("R7 vec%0d idle cycle", v), ti, V_EIDL[v]);
      chk($sformatf("R7 vec%0d row closed", v), int'(row_open_o), 0);
    end

    // R3 zero interval
    idle_off();
    interval_i = '0; enable_i = 1'b1;
    @(negedge clk_i);
    chk("R3 cfg_err", int'(cfg_err_o), 1);
    k = 0;
    repeat (40) begin @(negedge clk_i); if (ref_req_o) k++; end
    chk("R3 no request", k, 0);

    // R4 stray grant, then request held
    idle_off();
    interval_i = 12'd40; t_ras_i = 4'd6; t_rp_i = 4'd3; enable_i = 1'b1;
    repeat (5) @(negedge clk_i);
    ref_gnt_i = 1'b1;
    @(negedge clk_i);
    ref_gnt_i = 1'b0;
    k = 0;
    repeat (3) begin @(negedge clk_i); if (busy_o | cmd_refresh_o | cmd_pre_all_o) k++; end
    chk("R4 stray grant ignored", k, 0);
    wait_req(k);
    k = 0;
    repeat (10) begin @(negedge clk_i); if (ref_req_o) k++; end
    chk("R4 request held", k, 10);

    // R8 two owed
    idle_off();
    interval_i = 12'd30; enable_i = 1'b1;
    repeat (61) @(negedge clk_i);
    chk("R8 no overflow at two owed", int'(owed_ovf_o), 0);
    chk("R8 request up", int'(ref_req_o), 1);
    grant_run(tp, tr, ti, np, b1);
    chk("R8 first idle", ti, 10);
    chk("R8 second request at idle", int'(ref_req_o), 1);
    grant_run(tp, tr, ti, np, b1);
    chk("R8 second refresh", tr, 1);
    chk("R8 debt cleared", int'(ref_req_o), 0);

    // R8 overflow, R9 clear
    idle_off();
    interval_i = 12'd5; enable_i = 1'b1;
    repeat (15) @(negedge clk_i);
    chk("R8 overflow before third", int'(owed_ovf_o), 0);
    @(negedge clk_i);
    chk("R8 overflow on third", int'(owed_ovf_o), 1);
    repeat (7) @(negedge clk_i);
    chk("R8 overflow sticky", int'(owed_ovf_o), 1);
    enable_i = 1'b0;
    @(negedge clk_i);
    chk("R9 overflow cleared", int'(owed_ovf_o), 0);
    chk("R9 request cleared", int'(ref_req_o), 0);

    // R10 page tracking
    idle_off();
    interval_i = 12'd4000; enable_i = 1'b1;
    acc_bank_i = 2'd1; acc_row_i = 13'd5; acc_act_i = 1'b1;
    @(negedge clk_i);
    acc_act_i = 1'b0;
    chk("R10 open", int'(row_open_o), 1);
    chk("R10 open row", int'(open_row_o), 5);
    chk("R10 open bank", int'(open_bank_o), 1);
    chk("R10 same page no conflict", int'(acc_conflict_o), 0);
    acc_row_i = 13'd6; #1;
    chk("R10 same bank other row", int'(acc_conflict_o), 1);
    acc_row_i = 13'd5; acc_bank_i = 2'd2; #1;
    chk("R10 other bank same row", int'(acc_conflict_o), 1);
    acc_pre_i = 1'b1;
    @(negedge clk_i);
    acc_pre_i = 1'b0;
    chk("R10 precharge closes", int'(row_open_o), 0);
    chk("R10 no conflict when closed", int'(acc_conflict_o), 0);
    acc_act_i = 1'b1;
    @(negedge clk_i);
    acc_act_i = 1'b0;
    enable_i = 1'b0;
    @(negedge clk_i);
    chk("R9 disable closes row", int'(row_open_o), 0);

    // R10 activation during busy ignored
    idle_off();
    interval_i = 12'd10; t_ras_i = 4'd6; t_rp_i = 4'd3; enable_i = 1'b1;
    wait_req(k);
    ref_gnt_i = 1'b1;
    @(negedge clk_i);
    ref_gnt_i = 1'b0;
    acc_act_i = 1'b1; acc_bank_i = 2'd3; acc_row_i = 13'd77;
    @(negedge clk_i);
    acc_act_i = 1'b0;
    k = 0;
    while (busy_o && k < 40) begin @(negedge clk_i); k++; end
    chk("R10 activation while busy ignored", int'(row_open_o), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule